// File: doc/BRIEF.md
# EPROM programming pulse sequencer

This block sits on the programmer side of a word-wide UV-erasable memory. It writes an image into the device. After a start strobe it raises the programming supplies and waits a settling time. It then walks every address in ascending order. For each address it fetches the target word from a source port and applies a fixed-length program pulse. After each pulse it reads the location back. It keeps pulsing until the word matches or the pulse budget for that address runs out. A target word of all ones needs no pulse, because erased cells already read as one, so such an address is skipped.

Once the last address is programmed, the sequencer switches to the nominal-supply condition and waits the settling time again. It then compares every location against the image in a second pass. A clean run ends with a one-cycle completion strobe. Any address that exhausts its pulse budget, or any mismatch in the final pass, ends the run with a sticky error flag and the offending address held. Analog supply generation is outside the block: it only raises two selection flags.

The pulse length is derived from the clock frequency in MHz and a pulse time in microseconds. The pulse budget, the settling time and the read wait are all parameters.

Top module: `eprom_prog_seq`

## Requirements
- R1: While reset is held, and when idle, the outputs are at rest: romCeN=1, romOeN=1, romDataOe=0, supplyProg=0, supplyVerify=0, busy=0, done=0 and fail=0.
- R2: Each program pulse holds romCeN low for exactly CLK_MHZ*PULSE_US consecutive cycles. During the pulse romOeN=1, romDataOe=1 with romDataOut equal to the target word, supplyProg=1 and supplyVerify=0.
- R3: After every pulse the location is read back with romOeN=0 and romCeN=1. A mismatch causes another pulse at the same address. A match moves on to the next address. At the end of a clean run every location holds its target word.
- R4: When MAX_PULSES pulses at one address have not produced a match, the run stops. fail goes to 1 and failAddr holds that address. No further pulse is issued and done is not asserted.
- R5: An address whose target word is all ones (every bit 1) receives no pulse.
- R6: Addresses are programmed in ascending order from 0 to 2^ADDR_W-1, and each address is fetched once per pass.
- R7: At least SETUP_CYCLES cycles pass between the rise of a supply flag and the first pulse or read made under it. The two flags are never high together.
- R8: After the last address, supplyVerify=1 with supplyProg=0 and no pulse is issued. Every address is read and compared in ascending order. The first mismatch sets fail and latches that address in failAddr, and the pass stops there.
- R9: busy is 1 from the cycle after start until the run ends. A clean run raises done for exactly one cycle with fail=0.
- R10: A new start clears fail, so fail reads 0 on the cycle after start is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle |
| srcAddr | output | ADDR_W | Address of the image word requested from the source |
| srcData | input | DATA_W | Image word, valid one cycle after srcAddr changes |
| romAddr | output | ADDR_W | Address bus to the memory |
| romDataOut | output | DATA_W | Word driven onto the data bus during a pulse |
| romDataOe | output | 1 | Data bus drive enable |
| romDataIn | input | DATA_W | Word read back from the memory |
| romCeN | output | 1 | Chip enable / program strobe, active low |
| romOeN | output | 1 | Output enable, active low |
| supplyProg | output | 1 | Selects raised supply plus program voltage |
| supplyVerify | output | 1 | Selects nominal supply for the final pass |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle strobe at the end of a clean run |
| fail | output | 1 | Sticky error flag |
| failAddr | output | ADDR_W | Address that caused the error |

## Verification
The assertions assume three things about the environment. The source answers a new srcAddr with the matching word one cycle later. The memory presents a location on romDataIn within READ_CYCLES of romOeN falling. The image does not change during a run. The stimulus meets these conditions with a registered source model and a memory model read combinationally. The memory model programs cells (clears ones) only after a per-address number of pulses. It can also flip a bit just as the nominal-supply pass begins. The assertions further assume that start is pulsed only while the block is idle, and the bench waits for busy to drop before starting again.

// File: rtl/epsq_pkg.sv
package epsq_pkg;

  typedef enum logic [1:0] {
    TM_SETUP = 2'd0,
    TM_PULSE = 2'd1,
    TM_READ  = 2'd2
  } timerSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      addrClr;
    logic      addrInc;
    logic      wordLoad;
    logic      tryClr;
    logic      tryInc;
    logic      timerLoad;
    timerSel_e timerSel;
    logic      failLatch;
    logic      failClr;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic timerZero;
    logic addrLast;
    logic tryMax;
    logic wordOnes;
    logic wordMatch;
  } dpStatus_t;

  typedef enum logic [3:0] {
    S_IDLE    = 4'd0,
    S_PSETUP  = 4'd1,
    S_PFETCH  = 4'd2,
    S_PLOAD   = 4'd3,
    S_PDECIDE = 4'd4,
    S_PPULSE  = 4'd5,
    S_PREAD   = 4'd6,
    S_VSETUP  = 4'd7,
    S_VFETCH  = 4'd8,
    S_VLOAD   = 4'd9,
    S_VREAD   = 4'd10,
    S_DONE    = 4'd11
  } seqState_e;

endpackage

// File: rtl/epsq_datapath.sv
module epsq_datapath
  import epsq_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int MAX_PULSES   = 25,
  parameter int SETUP_CYCLES = 500,
  parameter int PULSE_CYCLES = 25000,
  parameter int READ_CYCLES  = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] romDataIn,
  output dpStatus_t         status,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] word,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr
);

  localparam int TRY_W    = $clog2(MAX_PULSES + 1);
  localparam int T_MAX_A  = (SETUP_CYCLES > PULSE_CYCLES) ? SETUP_CYCLES : PULSE_CYCLES;
  localparam int T_MAX    = (T_MAX_A > READ_CYCLES) ? T_MAX_A : READ_CYCLES;
  localparam int TIMER_W  = $clog2(T_MAX + 1);
  localparam logic [TIMER_W-1:0] SETUP_LD = TIMER_W'(SETUP_CYCLES - 1);
  localparam logic [TIMER_W-1:0] PULSE_LD = TIMER_W'(PULSE_CYCLES - 1);
  localparam logic [TIMER_W-1:0] READ_LD  = TIMER_W'(READ_CYCLES - 1);
  localparam logic [TRY_W-1:0]   TRY_LIM  = TRY_W'(MAX_PULSES);

  logic [TIMER_W-1:0] timer;
  logic [TIMER_W-1:0] timerLd;
  logic [TRY_W-1:0]   tries;

  // address walker
  always_ff @(posedge clk) begin
    if (!rstN)             addr <= '0;
    else if (stb.addrClr)  addr <= '0;
    else if (stb.addrInc)  addr <= addr + 1'b1;
  end

  // target word capture
  always_ff @(posedge clk) begin
    if (!rstN)             word <= '1;
    else if (stb.wordLoad) word <= srcData;
  end

  // pulse budget counter
  always_ff @(posedge clk) begin
    if (!rstN)            tries <= '0;
    else if (stb.tryClr)  tries <= '0;
    else if (stb.tryInc)  tries <= tries + 1'b1;
  end

  // shared down-counter for settle, pulse and read windows
  always_comb begin
    case (stb.timerSel)
      TM_SETUP: timerLd = SETUP_LD;
      TM_PULSE: timerLd = PULSE_LD;
      TM_READ:  timerLd = READ_LD;
      default:  timerLd = READ_LD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              timer <= '0;
    else if (stb.timerLoad) timer <= timerLd;
    else if (timer != '0)   timer <= timer - 1'b1;
  end

  // error capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fail     <= 1'b0;
      failAddr <= '0;
    end else if (stb.failClr) begin
      fail     <= 1'b0;
      failAddr <= '0;
    end else if (stb.failLatch) begin
      fail     <= 1'b1;
      failAddr <= addr;
    end
  end

  always_comb begin
    status.timerZero = (timer == '0);
    status.addrLast  = (addr == {ADDR_W{1'b1}});
    status.tryMax    = (tries >= TRY_LIM);
    status.wordOnes  = &word;
    status.wordMatch = (romDataIn == word);
  end

  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    tries <= TRY_LIM); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !stb.failClr) |=> fail); // R4
  AST_FAIL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !stb.failClr && !stb.failLatch) |=> $stable(failAddr)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    stb.addrInc |-> !status.addrLast); // R6

endmodule

// File: rtl/epsq_control.sv
module epsq_control
  import epsq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  dpStatus_t  status,
  output ctlStrobe_t stb,
  output logic       romCeN,
  output logic       romOeN,
  output logic       romDataOe,
  output logic       supplyProg,
  output logic       supplyVerify,
  output logic       busy,
  output logic       done
);

  seqState_e state;
  seqState_e nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    case (state)
      S_IDLE: begin
        if (start) begin
          stb.failClr   = 1'b1;
          stb.addrClr   = 1'b1;
          stb.timerLoad = 1'b1;
          stb.timerSel  = TM_SETUP;
          nextState     = S_PSETUP;
        end
      end
      S_PSETUP: if (status.timerZero) nextState = S_PFETCH;
      S_PFETCH: nextState = S_PLOAD;
      S_PLOAD: begin
        stb.wordLoad = 1'b1;
        stb.tryClr   = 1'b1;
        nextState    = S_PDECIDE;
      end
      S_PDECIDE: begin
        if (status.wordOnes) begin
          if (status.addrLast) begin
            stb.addrClr   = 1'b1;
            stb.timerLoad = 1'b1;
            stb.timerSel  = TM_SETUP;
            nextState     = S_VSETUP;
          end else begin
            stb.addrInc = 1'b1;
            nextState   = S_PFETCH;
          end
        end else begin
          stb.timerLoad = 1'b1;
          stb.timerSel  = TM_PULSE;
          nextState     = S_PPULSE;
        end
      end
      S_PPULSE: begin
        if (status.timerZero) begin
          stb.tryInc    = 1'b1;
          stb.timerLoad = 1'b1;
          stb.timerSel  = TM_READ;
          nextState     = S_PREAD;
        end
      end
      S_PREAD: begin
        if (status.timerZero) begin
          if (status.wordMatch) begin
            if (status.addrLast) begin
              stb.addrClr   = 1'b1;
              stb.timerLoad = 1'b1;
              stb.timerSel  = TM_SETUP;
              nextState     = S_VSETUP;
            end else begin
              stb.addrInc = 1'b1;
              nextState   = S_PFETCH;
            end
          end else if (status.tryMax) begin
            stb.failLatch = 1'b1;
            nextState     = S_IDLE;
          end else begin
            stb.timerLoad = 1'b1;
            stb.timerSel  = TM_PULSE;
            nextState     = S_PPULSE;
          end
        end
      end
      S_VSETUP: if (status.timerZero) nextState = S_VFETCH;
      S_VFETCH: nextState = S_VLOAD;
      S_VLOAD: begin
        stb.wordLoad  = 1'b1;
        stb.timerLoad = 1'b1;
        stb.timerSel  = TM_READ;
        nextState     = S_VREAD;
      end
      S_VREAD: begin
        if (status.timerZero) begin
          if (!status.wordMatch) begin
            stb.failLatch = 1'b1;
            nextState     = S_IDLE;
          end else if (status.addrLast) begin
            nextState = S_DONE;
          end else begin
            stb.addrInc = 1'b1;
            nextState   = S_VFETCH;
          end
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_comb begin
    romCeN       = (state != S_PPULSE);
    romOeN       = !((state == S_PREAD) || (state == S_VREAD));
    romDataOe    = (state == S_PPULSE);
    supplyProg   = (state == S_PSETUP) || (state == S_PFETCH) || (state == S_PLOAD) ||
                   (state == S_PDECIDE) || (state == S_PPULSE) || (state == S_PREAD);
    supplyVerify = (state == S_VSETUP) || (state == S_VFETCH) || (state == S_VLOAD) ||
                   (state == S_VREAD);
    busy         = (state != S_IDLE);
    done         = (state == S_DONE);
  end

  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romCeN) |-> $past(status.timerZero)); // R2
  AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(romCeN) && supplyProg) |-> !romOeN); // R3
  AST_SKIP_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PDECIDE && status.wordOnes) |=> romCeN); // R5
  AST_SUPPLY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(supplyProg && supplyVerify)); // R7
  AST_VERIFY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    supplyVerify |-> (romCeN && !romDataOe)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import epsq_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int CLK_MHZ      = 250,
  parameter int PULSE_US     = 100,
  parameter int MAX_PULSES   = 25,
  parameter int SETUP_CYCLES = 500,
  parameter int READ_CYCLES  = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] srcAddr,
  input  logic [DATA_W-1:0] srcData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] romDataOut,
  output logic              romDataOe,
  input  logic [DATA_W-1:0] romDataIn,
  output logic              romCeN,
  output logic              romOeN,
  output logic              supplyProg,
  output logic              supplyVerify,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] failAddr
);

  localparam int PULSE_CYCLES = CLK_MHZ * PULSE_US;

  ctlStrobe_t        stb;
  dpStatus_t         status;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] word;

  epsq_control ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .status       (status),
    .stb          (stb),
    .romCeN       (romCeN),
    .romOeN       (romOeN),
    .romDataOe    (romDataOe),
    .supplyProg   (supplyProg),
    .supplyVerify (supplyVerify),
    .busy         (busy),
    .done         (done)
  );

  epsq_datapath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .MAX_PULSES   (MAX_PULSES),
    .SETUP_CYCLES (SETUP_CYCLES),
    .PULSE_CYCLES (PULSE_CYCLES),
    .READ_CYCLES  (READ_CYCLES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .srcData   (srcData),
    .romDataIn (romDataIn),
    .status    (status),
    .addr      (addr),
    .word      (word),
    .fail      (fail),
    .failAddr  (failAddr)
  );

  assign srcAddr    = addr;
  assign romAddr    = addr;
  assign romDataOut = word;

endmodule

// File: tb/eprom_prog_seq_tb_top.sv
module eprom_prog_seq_tb_top;

  localparam int AW    = 3;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;
  localparam int CLKM  = 1;
  localparam int PUS   = 20;
  localparam int PULSE = CLKM * PUS;
  localparam int MAXP  = 4;
  localparam int SETUP = 5;
  localparam int READC = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] srcAddr, romAddr, failAddr;
  logic [DW-1:0] srcData, romDataOut, romDataIn;
  logic romDataOe, romCeN, romOeN, supplyProg, supplyVerify, busy, done, fail;

  eprom_prog_seq #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(CLKM), .PULSE_US(PUS),
    .MAX_PULSES(MAXP), .SETUP_CYCLES(SETUP), .READ_CYCLES(READC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .srcAddr(srcAddr), .srcData(srcData),
    .romAddr(romAddr), .romDataOut(romDataOut), .romDataOe(romDataOe),
    .romDataIn(romDataIn), .romCeN(romCeN), .romOeN(romOeN),
    .supplyProg(supplyProg), .supplyVerify(supplyVerify),
    .busy(busy), .done(done), .fail(fail), .failAddr(failAddr)
  );

  logic [DW-1:0] image [DEPTH];
  logic [DW-1:0] mem   [DEPTH];
  int            need  [DEPTH];
  int            seen  [DEPTH];
  logic [AW-1:0] expQ [$];

  int checks = 0;
  int fails  = 0;

  // image source with one cycle latency
  always_ff @(posedge clk) srcData <= image[srcAddr];
  // memory model read path
  always_comb romDataIn = romOeN ? '0 : mem[romAddr];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor state
  bit            prevCe = 1'b1, prevOe = 1'b1, prevProg = 1'b0, prevVer = 1'b0;
  bit            pulseOk = 1'b1, waitProg = 1'b0, waitVer = 1'b0, verPulseBad = 1'b0;
  bit            corruptEn = 1'b0;
  int            corruptAddr = 0;
  int            lowCnt = 0, sinceProg = 0, sinceVer = 0, verReads = 0, doneCnt = 0;
  logic [DW-1:0] pulseData;

  // monitor: pops the scoreboard at each pulse end and models the cells
  always @(negedge clk) begin
    if (rstN) begin
      if (!romCeN) begin
        lowCnt++;
        pulseData = romDataOut;
        if (!(romOeN && romDataOe && supplyProg && !supplyVerify &&
              romDataOut == image[romAddr])) pulseOk = 1'b0;
        if (supplyVerify) verPulseBad = 1'b1;
      end
      if (romCeN && !prevCe) begin
        check(lowCnt == PULSE, "R2", "pulse width", lowCnt, PULSE);
        check(pulseOk, "R2", "pulse bus levels", pulseOk, 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R4", "unexpected pulse at addr", romAddr, -1);
        end else begin
          logic [AW-1:0] e;
          e = expQ.pop_front();
          check(romAddr == e, "R6", "pulse address order", romAddr, e);
        end
        seen[romAddr]++;
        if (seen[romAddr] >= need[romAddr]) mem[romAddr] = mem[romAddr] & pulseData;
        lowCnt  = 0;
        pulseOk = 1'b1;
      end
      if (supplyProg && !prevProg) begin
        sinceProg = 0;
        waitProg  = 1'b1;
      end else if (supplyProg) sinceProg++;
      if (waitProg && supplyProg && (!romCeN || !romOeN)) begin
        check(sinceProg >= SETUP, "R7", "program settle cycles", sinceProg, SETUP);
        waitProg = 1'b0;
      end
      if (supplyVerify && !prevVer) begin
        sinceVer = 0;
        waitVer  = 1'b1;
        if (corruptEn) mem[corruptAddr] = mem[corruptAddr] ^ 16'h0001;
      end else if (supplyVerify) sinceVer++;
      if (waitVer && supplyVerify && !romOeN) begin
        check(sinceVer >= SETUP, "R7", "verify settle cycles", sinceVer, SETUP);
        waitVer = 1'b0;
      end
      if (supplyVerify && !romOeN && prevOe) verReads++;
      if (done) doneCnt++;
      if (supplyProg && supplyVerify) check(1'b0, "R7", "both supply flags", 1, 0);
    end
    prevCe   = romCeN;
    prevOe   = romOeN;
    prevProg = supplyProg;
    prevVer  = supplyVerify;
  end

  // driver: erases the model, loads the scoreboard, starts and waits
  task automatic runImage(input string tag, input bit expFail, input int expAddr,
                          input int expReads);
    int cyc;
    for (int a = 0; a < DEPTH; a++) begin
      mem[a]  = '1;
      seen[a] = 0;
    end
    expQ.delete();
    for (int a = 0; a < DEPTH; a++) begin
      if (image[a] != '1) begin
        int n;
        n = (need[a] > MAXP) ? MAXP : need[a];
        for (int k = 0; k < n; k++) expQ.push_back(AW'(a));
        if (need[a] > MAXP) break;
      end
    end
    doneCnt     = 0;
    verReads    = 0;
    verPulseBad = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R9", {tag, " busy after start"}, busy, 1);
    check(fail == 1'b0, "R10", {tag, " fail cleared by start"}, fail, 0);
    cyc = 0;
    while (busy && cyc < 40000) begin
      @(negedge clk);
      cyc++;
    end
    check(!busy, "R9", {tag, " run finished before watchdog"}, busy, 0);
    check(expQ.size() == 0, "R3", {tag, " all expected pulses issued"}, expQ.size(), 0);
    check(!verPulseBad, "R8", {tag, " no pulse in verify pass"}, verPulseBad, 0);
    check(verReads == expReads, "R8", {tag, " verify reads"}, verReads, expReads);
    if (expFail) begin
      check(fail == 1'b1, "R4", {tag, " fail flag"}, fail, 1);
      check(failAddr == AW'(expAddr), "R4", {tag, " fail address"}, failAddr, expAddr);
      check(doneCnt == 0, "R4", {tag, " no done on failure"}, doneCnt, 0);
    end else begin
      check(fail == 1'b0, "R9", {tag, " fail low"}, fail, 0);
      check(doneCnt == 1, "R9", {tag, " done cycles"}, doneCnt, 1);
      for (int a = 0; a < DEPTH; a++)
        check(mem[a] == image[a], "R3", {tag, " programmed word"}, mem[a], image[a]);
    end
    @(negedge clk);
    check(romCeN && romOeN && !romDataOe && !supplyProg && !supplyVerify && !done,
          "R1", {tag, " idle outputs"}, {romCeN, romOeN, romDataOe, supplyProg, supplyVerify}, 5'b11000);
  endtask

  task automatic loadBase();
    image[0] = 16'h1234; need[0] = 1;
    image[1] = 16'hFFFF; need[1] = 0;
    image[2] = 16'h0000; need[2] = 3;
    image[3] = 16'hA5A5; need[3] = 2;
    image[4] = 16'hFFFF; need[4] = 0;
    image[5] = 16'h7FFE; need[5] = MAXP;
    image[6] = 16'h8001; need[6] = 1;
    image[7] = 16'h00FF; need[7] = 2;
  endtask

  initial begin
    loadBase();
    for (int a = 0; a < DEPTH; a++) begin
      mem[a]  = '1;
      seen[a] = 0;
    end
    repeat (3) @(negedge clk);
    check(romCeN && romOeN && !romDataOe && !supplyProg && !supplyVerify &&
          !busy && !done && !fail, "R1", "reset outputs",
          {romCeN, romOeN, romDataOe, supplyProg, supplyVerify, busy, done, fail}, 8'b11000000);
    rstN = 1'b1;
    @(negedge clk);

    // clean run; addr 5 needs exactly the budget, ones words skipped
    runImage("clean", 1'b0, 0, DEPTH);
    check(seen[1] == 0 && seen[4] == 0, "R5", "all-ones words not pulsed", seen[1] + seen[4], 0);
    check(seen[2] == 3, "R3", "retries at addr 2", seen[2], 3);

    // cell disturbed at start of the nominal pass
    corruptEn   = 1'b1;
    corruptAddr = 5;
    runImage("verify-miss", 1'b1, 5, 6);
    corruptEn   = 1'b0;

    // addr 3 never programs within the budget
    need[3] = MAXP + 1;
    runImage("budget", 1'b1, 3, 0);
    check(seen[3] == MAXP, "R4", "pulses at failing addr", seen[3], MAXP);
    check(seen[4] + seen[5] + seen[6] + seen[7] == 0, "R4", "no pulse after abort",
          seen[4] + seen[5] + seen[6] + seen[7], 0);

    // fully erased image, also clears fail from previous run
    for (int a = 0; a < DEPTH; a++) begin
      image[a] = '1;
      need[a]  = 0;
    end
    runImage("blank", 1'b0, 0, DEPTH);
    check(seen[0] + seen[7] == 0, "R5", "blank image not pulsed", seen[0] + seen[7], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // global watchdog
  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule